// File: doc/BRIEF.md
# Single-Flag Compare and Branch Unit

This block holds the condition logic of a small processor that keeps one true/false status flag instead of a set of condition codes. Each cycle it receives a decoded operation code, two register values, the current program counter and an 8-bit branch displacement. Only the three compare operations write the flag. Every other operation, ordinary arithmetic included, leaves it as it was.

The two conditional branches read the flag. Branch-if-true is taken when the flag is 1 and branch-if-false is taken when it is 0. The unit also returns the branch target in the same cycle. A compare writes the flag on the clock edge that ends its cycle, so a branch in the next cycle already sees the new value. The execute stage can therefore place compare, add and branch back to back.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the flag is cleared to 0. After reset, `flag_o` reads 0.
- R2: Op code 3 (signed greater-or-equal compare) sets the flag to 1 at the next clock edge when `opa_i` is at least `opb_i` in two's-complement ordering. Otherwise it sets the flag to 0.
- R3: Op code 4 (unsigned higher-or-same compare) sets the flag to 1 at the next clock edge when `opa_i` is at least `opb_i` as an unsigned number. Otherwise it sets the flag to 0.
- R4: Op code 2 (equality compare) sets the flag to 1 at the next clock edge when `opa_i` equals `opb_i`. Otherwise it sets the flag to 0.
- R5: Op codes 0 (no-op), 1 (add), 5, 6 and 7 (other arithmetic) leave the flag unchanged.
- R6: `br_taken_o` is 1 during op code 5 (branch-if-true) exactly when the flag is 1, and during op code 6 (branch-if-false) exactly when the flag is 0. For every other op code it is 0.
- R7: `br_target_o` equals `pc_i` + 4 + 2 × (`disp_i` sign-extended from 8 bits), modulo 2^32. It is combinational.
- R8: A branch in the cycle right after a compare is decided on that compare's result, even when an add sits between a compare and a later branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Decoded operation code (encodings in R2–R6) |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand or compared value |
| pc_i | input | 32 | Address of the current operation |
| disp_i | input | 8 | Signed branch displacement in 2-byte units |
| flag_o | output | 1 | Current status flag |
| br_taken_o | output | 1 | Branch taken in this cycle |
| br_target_o | output | 32 | Branch target address |

## Verification
`br_taken_o` and `br_target_o` are combinational. They are due in the same cycle as the stimulus, so the bench samples them shortly after driving the inputs at the falling edge and before the next rising edge. `flag_o` changes one rising edge after a compare. The bench samples it a short delay after that edge and checks that the branch in the following table row acts on the new value. The vector table chains compares, adds, no-ops and branches, so each row's expected decision depends on the flag left by the rows before it.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

    localparam int XLEN       = 32;
    localparam int DISP_W     = 8;
    localparam int INSN_BYTES = 4;
    localparam int DISP_SHIFT = 1;
    localparam int OP_W       = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 3'd0,
        OP_ADD   = 3'd1,
        OP_CMPEQ = 3'd2,
        OP_CMPGE = 3'd3,
        OP_CMPHS = 3'd4,
        OP_BRT   = 3'd5,
        OP_BRF   = 3'd6,
        OP_ALU   = 3'd7
    } op_e;

    typedef struct packed {
        logic wr_en;
        logic value;
    } flag_upd_t;

    typedef struct packed {
        logic            taken;
        logic [XLEN-1:0] target;
    } br_res_t;

    function automatic logic is_compare(input op_e op);
        return (op == OP_CMPEQ) || (op == OP_CMPGE) || (op == OP_CMPHS);
    endfunction

    function automatic logic [XLEN-1:0] branch_target(
        input logic [XLEN-1:0]   pc,
        input logic [DISP_W-1:0] disp
    );
        logic [XLEN-1:0] sx;
        sx = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
        return pc + XLEN'(INSN_BYTES) + (sx << DISP_SHIFT);
    endfunction

endpackage

// File: rtl/cfu_compare.sv
module cfu_compare
    import cfu_pkg::*;
(
    input  op_e             op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output flag_upd_t       upd
);
    logic eq, ge_s, hs_u;

    always_comb begin
        eq   = (a == b);
        ge_s = ($signed(a) >= $signed(b));
        hs_u = (a >= b);
    end

    always_comb begin
        upd = '0;
        unique case (op)
            OP_CMPEQ: upd = '{wr_en: 1'b1, value: eq};
            OP_CMPGE: upd = '{wr_en: 1'b1, value: ge_s};
            OP_CMPHS: upd = '{wr_en: 1'b1, value: hs_u};
            default:  upd = '{wr_en: 1'b0, value: 1'b0};
        endcase
    end

    // R2 R3 R4
    always_comb begin
        if (!$isunknown(op)) begin
            upd_only_on_cmp_chk: assert (upd.wr_en == is_compare(op));
        end
    end
endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
    import cfu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_upd_t upd,
    output logic      flag_q
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (upd.wr_en)
            flag_q <= upd.value;
    end

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd.wr_en |=> $stable(flag_q));

    // R1
    flag_reset_chk: assert property (@(posedge clk)
        rst |=> !flag_q);
endmodule

// File: rtl/cfu_branch.sv
module cfu_branch
    import cfu_pkg::*;
(
    input  op_e               op,
    input  logic              flag,
    input  logic [XLEN-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output br_res_t           res
);
    always_comb begin
        res.target = branch_target(pc, disp);
        unique case (op)
            OP_BRT:  res.taken = flag;
            OP_BRF:  res.taken = !flag;
            default: res.taken = 1'b0;
        endcase
    end

    // R6
    always_comb begin
        if (!$isunknown(op) && res.taken) begin
            taken_only_branch_chk: assert (op == OP_BRT || op == OP_BRF);
        end
    end

    // R7
    always_comb begin
        if (!$isunknown(pc)) begin
            target_parity_chk: assert (res.target[0] == pc[0]);
        end
    end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [XLEN-1:0]   opa_i,
    input  logic [XLEN-1:0]   opb_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic              flag_o,
    output logic              br_taken_o,
    output logic [XLEN-1:0]   br_target_o
);
    op_e       op;
    flag_upd_t upd;
    logic      flag_q;
    br_res_t   br;

    assign op = op_e'(op_i);

    cfu_compare u_cmp (
        .op  (op),
        .a   (opa_i),
        .b   (opb_i),
        .upd (upd)
    );

    cfu_flag_reg u_flag (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .flag_q (flag_q)
    );

    cfu_branch u_br (
        .op   (op),
        .flag (flag_q),
        .pc   (pc_i),
        .disp (disp_i),
        .res  (br)
    );

    assign flag_o      = flag_q;
    assign br_taken_o  = br.taken;
    assign br_target_o = br.target;

    // R2
    ge_signed_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd3) |=> (flag_o == ($signed($past(opa_i)) >= $signed($past(opb_i)))));

    // R8
    brt_after_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd2 && opa_i == opb_i) ##1 (op_i == 3'd5) |-> br_taken_o);
endmodule

// File: tb/cond_flag_unit_test.sv
module cond_flag_unit_test;
    import cfu_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i;
    logic [31:0] opa_i, opb_i, pc_i;
    logic [7:0]  disp_i;
    logic        flag_o, br_taken_o;
    logic [31:0] br_target_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    cond_flag_unit uut (
        .clk(clk), .rst(rst), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .pc_i(pc_i), .disp_i(disp_i), .flag_o(flag_o),
        .br_taken_o(br_taken_o), .br_target_o(br_target_o)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] pc;
        logic [7:0]  disp;
        logic        exp_taken;
        logic        exp_flag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{3'd3, 32'd5,        32'd3,        32'h100, 8'h00, 1'b0, 1'b1}, // R2 5>=3
        '{3'd1, 32'd9,        32'd9,        32'h104, 8'h00, 1'b0, 1'b1}, // R5 add
        '{3'd5, 32'd0,        32'd0,        32'd100, 8'h10, 1'b1, 1'b1}, // R8 BT taken
        '{3'd6, 32'd0,        32'd0,        32'd104, 8'h03, 1'b0, 1'b1}, // R6 BF not
        '{3'd3, 32'hFFFFFFFF, 32'd1,        32'h200, 8'h00, 1'b0, 1'b0}, // R2 -1<1
        '{3'd1, 32'd1,        32'd2,        32'h204, 8'h00, 1'b0, 1'b0}, // R5 add
        '{3'd6, 32'd0,        32'd0,        32'd200, 8'hFE, 1'b1, 1'b0}, // R8 BF taken
        '{3'd4, 32'hFFFFFFFF, 32'd1,        32'h300, 8'h00, 1'b0, 1'b1}, // R3
        '{3'd5, 32'd0,        32'd0,        32'h304, 8'h7F, 1'b1, 1'b1}, // R6
        '{3'd2, 32'd7,        32'd7,        32'h308, 8'h00, 1'b0, 1'b1}, // R4 eq
        '{3'd2, 32'd7,        32'd8,        32'h30C, 8'h00, 1'b0, 1'b0}, // R4 ne
        '{3'd0, 32'd4,        32'd4,        32'h310, 8'h00, 1'b0, 1'b0}, // R5 nop
        '{3'd3, 32'hFFFFFFFB, 32'hFFFFFFFB, 32'h314, 8'h00, 1'b0, 1'b1}, // R2 equal
        '{3'd4, 32'd0,        32'd1,        32'h318, 8'h00, 1'b0, 1'b0}, // R3 0<1
        '{3'd7, 32'd3,        32'd3,        32'h31C, 8'h00, 1'b0, 1'b0}, // R5 alu
        '{3'd5, 32'd0,        32'd0,        32'h320, 8'h80, 1'b0, 1'b0}, // R6 BT not
        '{3'd3, 32'h80000000, 32'h7FFFFFFF, 32'h324, 8'h00, 1'b0, 1'b0}, // R2 min<max
        '{3'd4, 32'h80000000, 32'h7FFFFFFF, 32'h328, 8'h00, 1'b0, 1'b1}  // R3 unsigned
    };

    function automatic logic [31:0] exp_target(input logic [31:0] pc, input logic [7:0] d);
        return pc + 32'd4 + {{23{d[7]}}, d, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] pc, input logic [7:0] d);
        op_i = op; opa_i = a; opb_i = b; pc_i = pc; disp_i = d;
    endtask

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(3'd0, 0, 0, 0, 0);
        repeat (2) @(posedge clk);
        #2;
        check("R1 reset flag", {31'd0, flag_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].pc, VEC[i].disp);
            #2;
            check("R6 taken", {31'd0, br_taken_o}, {31'd0, VEC[i].exp_taken});
            check("R7 target", br_target_o, exp_target(VEC[i].pc, VEC[i].disp));
            @(posedge clk);
            #2;
            check("R2/R3/R4/R5 flag", {31'd0, flag_o}, {31'd0, VEC[i].exp_flag});
            @(negedge clk);
        end

        // R7 displacement extremes
        drive(3'd5, 0, 0, 32'h1000, 8'h80);
        #2;
        check("R7 disp -128", br_target_o, 32'h1000 + 32'd4 - 32'd256);
        drive(3'd5, 0, 0, 32'hFFFFFFFE, 8'h7F);
        #2;
        check("R7 wrap", br_target_o, 32'hFFFFFFFE + 32'd4 + 32'd254);
        @(negedge clk);

        // R8 compare, add, add, branch-if-true
        drive(3'd2, 32'h55, 32'h55, 0, 0);
        @(negedge clk);
        drive(3'd1, 32'h1, 32'h2, 0, 0);
        @(negedge clk);
        drive(3'd1, 32'h0, 32'h0, 0, 0);
        @(negedge clk);
        drive(3'd5, 0, 0, 32'h40, 8'h02);
        #2;
        check("R8 BT after adds", {31'd0, br_taken_o}, 32'd1);
        drive(3'd6, 0, 0, 32'h40, 8'h02);
        #2;
        check("R6 BF with flag 1", {31'd0, br_taken_o}, 32'd0);
        drive(3'd3, 32'd1, 32'd2, 0, 0);
        #2;
        check("R6 compare not taken", {31'd0, br_taken_o}, 32'd0);
        drive(3'd1, 0, 0, 0, 0);
        @(negedge clk);

        // R1 reset while flag is 1
        rst = 1'b1;
        drive(3'd2, 32'h9, 32'h9, 0, 0);
        @(posedge clk);
        #2;
        check("R1 reset over compare", {31'd0, flag_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        drive(3'd6, 0, 0, 32'h80, 8'h00);
        #2;
        check("R6 BF after reset", {31'd0, br_taken_o}, 32'd1);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule